// File: doc/BRIEF.md
# Two-Address Serial Memory Target with Write Protection

This block is a target on a two-wire serial bus (I2C style). It answers to two 7-bit target addresses. The first address opens a byte-wide memory array. The array holds 8192 bytes when `MEM_AW` is 13; the default build is smaller so that it elaborates quickly. The second address opens a file of 15 eight-bit control registers.

Each address keeps its own pointer. A host can therefore inspect or change the registers between memory transfers and still resume memory traffic at the address where it left off.

A two-bit field in the last register sets how much of the low end of the memory is protected against writes. The choices are none, the lowest quarter, the lowest half or the whole array. A data byte that targets a protected location is dropped and answered with a NACK.

Writes finish at bus speed, so the block never reports busy. The bus lines are oversampled in the block's clock domain. The data line is driven only low, through an open-drain enable.

Top module: `i2c_dual_target`

## Requirements
- R1: The block acknowledges only the target addresses `DEV_MEM` and `DEV_REG`. After any other address it drives nothing until the next START, and it never drives the data line while idle.
- R2: The memory pointer and the register pointer are separate. No register access changes the memory pointer, and a memory read that carries no address continues from the last memory pointer.
- R3: A memory write is addressed by two bytes, high byte first. Address bits at or above `MEM_AW` are ignored.
- R4: The memory pointer advances by one after every data byte, on writes and on reads. It wraps from the top location to 0.
- R5: The register pointer is loaded from one offset byte. Offsets above 14 load 0. The pointer advances after each register data byte and wraps from 14 to 0.
- R6: Register 14, bits [1:0], selects write protection. 00 protects nothing. 01 protects locations below one quarter of the array (0x40 when `MEM_AW` = 8). 10 protects locations below one half (0x80). 11 protects every location.
- R7: A data byte to a protected location is not stored and receives a NACK. The pointer does not advance, and the target ignores the bus until the next START or STOP.
- R8: During a read, a NACK from the controller ends the transfer and the target releases the data line.
- R9: Reset clears every register. Register 14, bits [1:0], instead keep their value when `backup_ok` is high during reset.
- R10: A repeated START in the middle of a transfer begins a new address phase. A write address followed by a repeated START and a read returns data from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| backup_ok | input | 1 | High when a backup supply keeps the protect bits during reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pulls the data line low when high |

## Verification
The bench builds the block with `MEM_AW` = 8, `DEV_MEM` = 0x50 and `DEV_REG` = 0x68. With a 256-byte array, one burst can fill the whole memory and carry the pointer past its wrap point. The quarter and half protect limits fall at 0x40 and 0x80, which the bench reaches with directed accesses on each side of every limit. Because 8 address bits sit below the high address byte, that whole byte is ignored. The bench sends random values in it to show that they have no effect.

// File: rtl/i2c_dual_pkg.sv
package i2c_dual_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_TX,
        ST_TX,
        ST_ACK_RX
    } bus_state_e;

    typedef enum logic [2:0] {
        RL_DEV,
        RL_MHI,
        RL_MLO,
        RL_ROFF,
        RL_DATA
    } byte_role_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    localparam int REG_COUNT = 15;
    localparam int REG_AW    = 4;
    localparam int WP_REG    = REG_COUNT - 1;

    // top2 = two most significant bits of the memory address
    function automatic logic wp_blocks(input logic [1:0] wp, input logic [1:0] top2);
        case (wp)
            2'b01:   return top2 == 2'b00;
            2'b10:   return top2[1] == 1'b0;
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_dual_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [2:0] scl_q;
    logic [2:0] sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
        end
    end

    always_comb begin
        ev.rise  = scl_q[1] & ~scl_q[2];
        ev.fall  = ~scl_q[1] & scl_q[2];
        ev.start = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
        ev.stop  = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
        ev.sda   = sda_q[1];
    end

endmodule

// File: rtl/i2c_byte_mem.sv
module i2c_byte_mem #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (we) arr[waddr] <= wdata;
    end

    assign rdata = arr[raddr];

endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
    import i2c_dual_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              backup_ok,
    input  logic              we,
    input  logic [REG_AW-1:0] ptr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [1:0]        wp
);
    logic [7:0] regv [REG_COUNT];

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        if (i == WP_REG) begin : g_wp
            always_ff @(posedge clk) begin
                if (rst) regv[i] <= backup_ok ? {6'b0, regv[i][1:0]} : 8'h00;
                else if (we && ptr == REG_AW'(i)) regv[i] <= wdata;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) regv[i] <= 8'h00;
                else if (we && ptr == REG_AW'(i)) regv[i] <= wdata;
            end
        end
    end

    assign rdata = (ptr < REG_AW'(REG_COUNT)) ? regv[ptr] : 8'h00;
    assign wp    = regv[WP_REG][1:0];

    // R9
    wp_cold_clear_chk: assert property (@(posedge clk)
        (rst && !backup_ok) |=> (wp == 2'b00));

endmodule

// File: rtl/i2c_dual_target.sv
module i2c_dual_target
    import i2c_dual_pkg::*;
#(
    parameter int         MEM_AW  = 11,
    parameter logic [6:0] DEV_MEM = 7'h50,
    parameter logic [6:0] DEV_REG = 7'h68
) (
    input  logic clk,
    input  logic rst,
    input  logic backup_ok,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    line_ev_t          ev;
    bus_state_e        state;
    byte_role_e        role;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg, txsh, addr_hi;
    logic              sel_mem, go_tx;
    logic [MEM_AW-1:0] mem_ptr;
    logic [REG_AW-1:0] reg_ptr, reg_next;
    logic [7:0]        mem_rdata, reg_rdata, rd_byte;
    logic [1:0]        wp;
    logic [15:0]       addr_full;
    logic              byte_end, dev_mem_hit, dev_reg_hit, blocked, byte_ok;
    logic              mem_we, reg_we;

    i2c_line_sync u_sync (.clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev));

    i2c_byte_mem #(.AW(MEM_AW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_ptr), .wdata(shreg),
        .raddr(mem_ptr), .rdata(mem_rdata)
    );

    i2c_ctl_regs u_regs (
        .clk(clk), .rst(rst), .backup_ok(backup_ok), .we(reg_we),
        .ptr(reg_ptr), .wdata(shreg), .rdata(reg_rdata), .wp(wp)
    );

    always_comb begin
        byte_end    = (state == ST_RX) && ev.fall && (bitcnt == 4'd8) && !ev.start && !ev.stop;
        dev_mem_hit = shreg[7:1] == DEV_MEM;
        dev_reg_hit = shreg[7:1] == DEV_REG;
        blocked     = wp_blocks(wp, mem_ptr[MEM_AW-1 -: 2]);
        case (role)
            RL_DEV:  byte_ok = dev_mem_hit || dev_reg_hit;
            RL_DATA: byte_ok = !(sel_mem && blocked);
            default: byte_ok = 1'b1;
        endcase
        mem_we    = byte_end && (role == RL_DATA) && sel_mem && byte_ok;
        reg_we    = byte_end && (role == RL_DATA) && !sel_mem;
        reg_next  = (reg_ptr == REG_AW'(WP_REG)) ? '0 : reg_ptr + 1'b1;
        rd_byte   = sel_mem ? mem_rdata : reg_rdata;
        addr_full = {addr_hi, shreg};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            role    <= RL_DEV;
            bitcnt  <= '0;
            shreg   <= '0;
            txsh    <= '0;
            addr_hi <= '0;
            sda_oe  <= 1'b0;
            sel_mem <= 1'b0;
            go_tx   <= 1'b0;
            mem_ptr <= '0;
            reg_ptr <= '0;
        end else if (ev.start) begin
            state  <= ST_RX;
            role   <= RL_DEV;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (ev.rise && bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_end) begin
                        bitcnt <= '0;
                        sda_oe <= byte_ok;
                        state  <= byte_ok ? ST_ACK_TX : ST_IDLE;
                        case (role)
                            RL_DEV: begin
                                sel_mem <= dev_mem_hit;
                                go_tx   <= shreg[0];
                                role    <= shreg[0] ? RL_DATA : (dev_mem_hit ? RL_MHI : RL_ROFF);
                            end
                            RL_MHI: begin
                                addr_hi <= shreg;
                                role    <= RL_MLO;
                            end
                            RL_MLO: begin
                                mem_ptr <= addr_full[MEM_AW-1:0];
                                role    <= RL_DATA;
                            end
                            RL_ROFF: begin
                                reg_ptr <= (shreg < 8'(REG_COUNT)) ? shreg[REG_AW-1:0] : '0;
                                role    <= RL_DATA;
                            end
                            default: begin
                                if (byte_ok) begin
                                    if (sel_mem) mem_ptr <= mem_ptr + 1'b1;
                                    else         reg_ptr <= reg_next;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK_TX: begin
                    if (ev.fall) begin
                        bitcnt <= go_tx ? 4'd1 : 4'd0;
                        txsh   <= rd_byte;
                        sda_oe <= go_tx ? ~rd_byte[7] : 1'b0;
                        state  <= go_tx ? ST_TX : ST_RX;
                    end
                end
                ST_TX: begin
                    if (ev.fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_ACK_RX;
                        end else begin
                            sda_oe <= ~txsh[6];
                            txsh   <= {txsh[6:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_ACK_RX: begin
                    if (ev.rise) begin
                        if (sel_mem) mem_ptr <= mem_ptr + 1'b1;
                        else         reg_ptr <= reg_next;
                        state <= ev.sda ? ST_IDLE : ST_ACK_TX;
                    end
                end
                default: sda_oe <= 1'b0;
            endcase
        end
    end

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R2
    reg_keeps_mptr_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> $stable(mem_ptr));

    // R4
    mptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (mem_ptr == MEM_AW'($past(mem_ptr) + 1'b1)));

    // R5
    rptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        reg_ptr <= REG_AW'(WP_REG));

    // R7
    refuse_nack_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_end && role == RL_DATA && sel_mem && blocked) |=> (!sda_oe && $stable(mem_ptr)));

endmodule

// File: tb/i2c_dual_target_tb_top.sv
module i2c_dual_target_tb_top;
    localparam int         AW   = 8;
    localparam int         SZ   = 1 << AW;
    localparam logic [6:0] DMEM = 7'h50;
    localparam logic [6:0] DREG = 7'h68;
    localparam int         Q    = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic backup_ok = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem_m [SZ];
    logic [7:0] regs_m [15];
    int mptr = 0;
    int rptr = 0;

    always #4 clk = ~clk;

    i2c_dual_target #(.MEM_AW(AW), .DEV_MEM(DMEM), .DEV_REG(DREG)) dut_i (
        .clk(clk), .rst(rst), .backup_ok(backup_ok),
        .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe)
    );

    function automatic bit prot(input int wp, input int a);
        return (wp == 3) || (wp == 2 && a < SZ / 2) || (wp == 1 && a < SZ / 4);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic wbit(input bit b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic rbit(output bit b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic wbyte(input logic [7:0] v, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        ack = !a;
    endtask

    task automatic rbyte(output logic [7:0] v, input bit mack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(!mack);
    endtask

    task automatic do_reset(input bit bk);
        backup_ok = bk;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 15; i++) regs_m[i] = (i == 14 && bk) ? {6'b0, regs_m[14][1:0]} : 8'h00;
        mptr = 0;
        rptr = 0;
        @(negedge clk);
        // R1: nothing driven straight after reset
        chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
    endtask

    task automatic mem_addr(input int addr);
        bit a;
        wbyte({DMEM, 1'b0}, a); chk(a, "R1 mem id ack", a, 1);
        // R3: bits above AW are random junk
        wbyte(8'($urandom), a); chk(a, "R3 addr hi ack", a, 1);
        wbyte(addr[7:0], a); chk(a, "R3 addr lo ack", a, 1);
        mptr = addr % SZ;
    endtask

    task automatic mem_wr(input int addr, input int n);
        bit a;
        logic [7:0] v;
        i2c_start();
        mem_addr(addr);
        for (int i = 0; i < n; i++) begin
            v = 8'($urandom);
            wbyte(v, a);
            if (prot(regs_m[14][1:0], mptr)) begin
                chk(!a, "R6 protected nack", a, 0);
                wbyte(8'($urandom), a);
                chk(!a, "R7 ignored after refusal", a, 0);
                break;
            end
            chk(a, "R6 unprotected ack", a, 1);
            mem_m[mptr] = v;
            mptr = (mptr + 1) % SZ;
        end
        i2c_stop();
    endtask

    task automatic read_run(input int n, input bit is_mem);
        logic [7:0] v;
        bit a;
        i2c_start();
        wbyte({is_mem ? DMEM : DREG, 1'b1}, a);
        chk(a, "R1 read id ack", a, 1);
        for (int i = 0; i < n; i++) begin
            rbyte(v, i != n - 1);
            if (is_mem) begin
                chk(v == mem_m[mptr], "R4 mem read data", v, mem_m[mptr]);
                mptr = (mptr + 1) % SZ;
            end else begin
                chk(v == regs_m[rptr], "R5 reg read data", v, regs_m[rptr]);
                rptr = (rptr == 14) ? 0 : rptr + 1;
            end
        end
        i2c_stop();
    endtask

    task automatic mem_rd(input int addr, input int n);
        logic [7:0] v;
        bit a;
        i2c_start();
        mem_addr(addr);
        // R10: repeated START into read
        i2c_start();
        wbyte({DMEM, 1'b1}, a);
        chk(a, "R10 restart read ack", a, 1);
        for (int i = 0; i < n; i++) begin
            rbyte(v, i != n - 1);
            chk(v == mem_m[mptr], "R10 read after restart", v, mem_m[mptr]);
            mptr = (mptr + 1) % SZ;
        end
        i2c_stop();
    endtask

    task automatic reg_wr(input int off, input int n, input int first);
        bit a;
        logic [7:0] v;
        i2c_start();
        wbyte({DREG, 1'b0}, a); chk(a, "R1 reg id ack", a, 1);
        wbyte(8'(off), a); chk(a, "R5 offset ack", a, 1);
        rptr = (off < 15) ? off : 0;
        for (int i = 0; i < n; i++) begin
            v = (i == 0 && first >= 0) ? 8'(first) : 8'($urandom);
            wbyte(v, a);
            chk(a, "R5 reg write ack", a, 1);
            regs_m[rptr] = v;
            rptr = (rptr == 14) ? 0 : rptr + 1;
        end
        i2c_stop();
    endtask

    task automatic reg_rd(input int off, input int n);
        bit a;
        i2c_start();
        wbyte({DREG, 1'b0}, a);
        wbyte(8'(off), a);
        rptr = (off < 15) ? off : 0;
        i2c_stop();
        read_run(n, 1'b0);
    endtask

    initial begin
        bit a, b;
        logic [7:0] v;
        int bnd [8] = '{0, 63, 64, 65, 127, 128, 129, 255};
        void'($urandom(32'd2024));
        do_reset(1'b0);

        // R9: cold reset clears the protect register
        reg_rd(14, 1);

        // R1: foreign address is not acknowledged
        i2c_start();
        wbyte({7'h33, 1'b0}, a);
        chk(!a, "R1 foreign id nack", a, 0);
        rbit(b);
        chk(b, "R1 line released", b, 1);
        i2c_stop();

        // R4: fill array and wrap past the top
        mem_wr(0, SZ + 2);
        mem_rd(SZ - 3, 6);

        // R2: register traffic leaves memory pointer alone
        mem_rd(17, 2);
        reg_wr(3, 4, -1);
        read_run(3, 1'b1);

        // R5: pointer wrap and out-of-range offset
        reg_wr(13, 3, -1);
        regs_m[14][1:0] = regs_m[14][1:0];
        reg_wr(14, 1, 0);
        reg_rd(13, 4);
        reg_wr(8'h20, 1, 8'h5A);
        reg_rd(0, 1);

        // R6, R7: each protect setting at its boundaries
        for (int w = 0; w < 4; w++) begin
            reg_wr(14, 1, 8'hF0 | w);
            for (int k = 0; k < 8; k++) mem_wr(bnd[k], 2);
            mem_rd(0, 2);
            mem_rd(126, 4);
        end
        reg_wr(14, 1, 0);

        // R8: controller NACK ends a read
        i2c_start();
        mem_addr(40);
        i2c_start();
        wbyte({DMEM, 1'b1}, a);
        rbyte(v, 1'b0);
        chk(v == mem_m[40], "R8 last byte", v, mem_m[40]);
        rbit(b);
        chk(b, "R8 released after nack", b, 1);
        i2c_stop();

        // R9: protect bits survive reset with backup
        reg_wr(14, 1, 8'hA2);
        do_reset(1'b1);
        reg_rd(14, 1);
        do_reset(1'b0);
        reg_rd(14, 1);

        // random traffic
        for (int t = 0; t < 30; t++) begin
            case ($urandom % 4)
                0: reg_wr(14, 1, int'($urandom % 4));
                1: mem_wr(int'($urandom % SZ), 1 + int'($urandom % 4));
                2: mem_rd(int'($urandom % SZ), 1 + int'($urandom % 4));
                default: read_run(1 + int'($urandom % 3), 1'b1);
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule